// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address through a four-entry table of segments. The two most significant address bits pick one entry. The remaining 30 bits form an offset. The offset is compared against that entry's limit and then added to the entry's start address. A lookup that is not permitted produces a fault flag in place of an address.

Software loads the table through a single-cycle write port. Each write sets the start address, the limit and the enable bit of one entry. Lookups arrive with a valid strobe. The answer appears on the response outputs exactly one clock later, and no back-pressure is applied. Typical use is in front of a memory port, where the fault flag aborts the access.

Top module: `seg_xlat_top`

## Requirements
- R1: Bits [31:30] of `req_vaddr` select the table entry (00 selects entry 0, 11 selects entry 3). Bits [29:0] are the offset.
- R2: A permitted lookup returns `rsp_paddr` equal to the entry's base plus the offset, with `rsp_fault` low. The result appears in the cycle after `req_valid`.
- R3: A lookup whose offset is greater than or equal to the entry's bound faults. Legal offsets therefore run from 0 to bound minus 1.
- R4: A lookup that selects an entry whose enable bit is clear faults, whatever the entry's base and bound hold.
- R5: A lookup faults when base plus offset does not fit in 30 bits.
- R6: A table write takes effect at the next clock edge. A lookup in the same cycle as the write sees the entry's previous contents, and a lookup in the following cycle sees the new contents.
- R7: After reset, `rsp_valid` is low and every entry is disabled, so any lookup faults.
- R8: `rsp_valid` is high in a cycle exactly when `req_valid` was high in the previous cycle.
- R9: Whenever `rsp_fault` is high, `rsp_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 30 | Physical start address for the entry |
| cfg_bound | input | 30 | Segment length; offsets below it are legal |
| cfg_en | input | 1 | Entry enable bit |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 30 | Translated physical address, zero on a fault |
| rsp_fault | output | 1 | Translation refused |

## Verification
On every cycle, the assertions enforce several properties. The response strobe must track the request one cycle late. A fault must force a zero address. A clean answer must come from an enabled entry, use an offset below its bound, and produce a result that has not wrapped below the base. A write must also land in the addressed entry on the next edge. Other behaviour can only be shown by the bench's scenarios. This covers the exact sum, the boundary offsets at bound minus one, bound and bound plus one, the carry case at the top of memory, the ordering of a write and a lookup in the same cycle, and the disabled state after reset. The bench checks these against its own model of the table.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    // Outcome of one table check; anything but XC_OK is a fault.
    typedef enum logic [1:0] {
        XC_OK    = 2'd0,
        XC_OFF   = 2'd1,
        XC_LIMIT = 2'd2,
        XC_WRAP  = 2'd3
    } xlat_chk_e;

endpackage

// File: rtl/seg_xlat_table.sv
module seg_xlat_table #(
    parameter int SEG_W = 2,
    parameter int PA_W  = 30,
    parameter int OFF_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [OFF_W-1:0] wr_bound,
    input  logic             wr_on,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base,
    output logic [OFF_W-1:0] rd_bound,
    output logic             rd_on
);

    localparam int NSEG = 1 << SEG_W;

    typedef struct packed {
        logic             on;
        logic [PA_W-1:0]  base;
        logic [OFF_W-1:0] bound;
    } ent_t;

    ent_t ent_arr [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        ent_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == SEG_W'(g))) begin
                ent_d.on    = wr_on;
                ent_d.base  = wr_base;
                ent_d.bound = wr_bound;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ent_arr[g] = ent_q;
    end

    // Read side sees registered contents only: writes land next cycle.
    assign rd_base  = ent_arr[rd_idx].base;
    assign rd_bound = ent_arr[rd_idx].bound;
    assign rd_on    = ent_arr[rd_idx].on;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> (ent_arr[$past(wr_idx)].base == $past(wr_base)) && (ent_arr[$past(wr_idx)].bound == $past(wr_bound)) && (ent_arr[$past(wr_idx)].on == $past(wr_on))); // R6

endmodule

// File: rtl/seg_xlat_calc.sv
module seg_xlat_calc
    import seg_xlat_pkg::*;
#(
    parameter int PA_W  = 30,
    parameter int OFF_W = 30
) (
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W-1:0] bound,
    input  logic             on,
    input  logic [OFF_W-1:0] offset,
    output logic [PA_W-1:0]  paddr,
    output xlat_chk_e        chk
);

    localparam int WIDE  = (OFF_W > PA_W) ? OFF_W : PA_W;
    localparam int SUM_W = WIDE + 1;

    logic [SUM_W-1:0] sum;
    logic             wrap;

    assign sum   = SUM_W'(base) + SUM_W'(offset);
    assign wrap  = |sum[SUM_W-1:PA_W];
    assign paddr = sum[PA_W-1:0];

    // Priority: disabled entry, then limit, then carry out of the address.
    always_comb begin
        if (!on)                  chk = XC_OFF;
        else if (offset >= bound) chk = XC_LIMIT;
        else if (wrap)            chk = XC_WRAP;
        else                      chk = XC_OK;
    end

endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
    import seg_xlat_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int SEG_W = 2,
    parameter int PA_W  = 30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [SEG_W-1:0]      cfg_idx,
    input  logic [PA_W-1:0]       cfg_base,
    input  logic [VA_W-SEG_W-1:0] cfg_bound,
    input  logic                  cfg_en,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    output logic                  rsp_valid,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  rsp_fault
);

    localparam int OFF_W = VA_W - SEG_W;

    typedef struct packed {
        logic            vld;
        logic            fault;
        logic [PA_W-1:0] pa;
    } rsp_t;

    logic [SEG_W-1:0] seg_sel;
    logic [OFF_W-1:0] offset;
    logic [PA_W-1:0]  sel_base;
    logic [OFF_W-1:0] sel_bound;
    logic             sel_on;
    logic [PA_W-1:0]  sum_pa;
    xlat_chk_e        chk;
    rsp_t             rsp_d, rsp_q;

    assign seg_sel = req_vaddr[VA_W-1:OFF_W];
    assign offset  = req_vaddr[OFF_W-1:0];

    seg_xlat_table #(.SEG_W(SEG_W), .PA_W(PA_W), .OFF_W(OFF_W)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_base  (cfg_base),
        .wr_bound (cfg_bound),
        .wr_on    (cfg_en),
        .rd_idx   (seg_sel),
        .rd_base  (sel_base),
        .rd_bound (sel_bound),
        .rd_on    (sel_on)
    );

    seg_xlat_calc #(.PA_W(PA_W), .OFF_W(OFF_W)) calc_i (
        .base   (sel_base),
        .bound  (sel_bound),
        .on     (sel_on),
        .offset (offset),
        .paddr  (sum_pa),
        .chk    (chk)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.vld   = req_valid;
        if (req_valid) begin
            rsp_d.fault = (chk != XC_OK);
            rsp_d.pa    = (chk == XC_OK) ? sum_pa : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.pa;

    AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R8
    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R8
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R9
    AST_OK_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && chk == XC_OK) |-> sel_on); // R4
    AST_HIT_BELOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_fault) |-> ($past(offset) < $past(sel_bound))); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_fault) |-> (rsp_paddr >= $past(sel_base))); // R5

endmodule

// File: tb/seg_xlat_top_tb_top.sv
`timescale 1ns/1ps
module seg_xlat_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_idx;
    logic [29:0] cfg_base;
    logic [29:0] cfg_bound;
    logic        cfg_en;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        rsp_valid;
    logic [29:0] rsp_paddr;
    logic        rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [29:0] m_base  [4];
    logic [29:0] m_bound [4];
    logic        m_en    [4];

    always #2 clk = ~clk;

    seg_xlat_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_bound(cfg_bound), .cfg_en(cfg_en),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    // Returns {fault, paddr} from the bench's own table model.
    function automatic logic [30:0] model_xlat(input logic [31:0] va);
        logic [1:0]  s;
        logic [29:0] off;
        logic [30:0] sum;
        s   = va[31:30];
        off = va[29:0];
        sum = {1'b0, m_base[s]} + {1'b0, off};
        if (!m_en[s] || off >= m_bound[s] || sum[30]) return {1'b1, 30'd0};
        return {1'b0, sum[29:0]};
    endfunction

    function automatic string class_tag(input logic [31:0] va);
        logic [1:0]  s;
        logic [30:0] sum;
        s   = va[31:30];
        sum = {1'b0, m_base[s]} + {1'b0, va[29:0]};
        if (!m_en[s])                   return "R4";
        if (va[29:0] >= m_bound[s])     return "R3";
        if (sum[30])                    return "R5";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic gv, input logic gf,
                         input logic [29:0] gp, input logic ev, input logic ef,
                         input logic [29:0] ep);
        checks++;
        if (gv !== ev || gf !== ef || gp !== ep) begin
            errors++;
            $display("FAIL %s: got vld=%0b fault=%0b pa=%h, expected vld=%0b fault=%0b pa=%h",
                     tag, gv, gf, gp, ev, ef, ep);
        end
    endtask

    // One cycle: drive at negedge, result checked at the following negedge.
    task automatic cycle(input logic we, input logic [1:0] idx, input logic [29:0] b,
                         input logic [29:0] bd, input logic en,
                         input logic rv, input logic [31:0] va, input string tag);
        logic [30:0] exp;
        string       t;
        cfg_we = we; cfg_idx = idx; cfg_base = b; cfg_bound = bd; cfg_en = en;
        req_valid = rv; req_vaddr = va;
        exp = model_xlat(va);
        t   = (tag == "") ? (rv ? class_tag(va) : "R8") : tag;
        @(posedge clk);
        if (we) begin m_base[idx] = b; m_bound[idx] = bd; m_en[idx] = en; end
        @(negedge clk);
        if (rv) check(t, rsp_valid, rsp_fault, rsp_paddr, 1'b1, exp[30], exp[29:0]);
        else    check(t, rsp_valid, rsp_fault, rsp_paddr, 1'b0, 1'b0, 30'd0);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [29:0] b, input logic [29:0] bd, input logic en);
        cycle(1'b1, idx, b, bd, en, 1'b0, 32'd0, "R8");
    endtask

    task automatic rd(input logic [31:0] va, input string tag);
        cycle(1'b0, 2'd0, 30'd0, 30'd0, 1'b0, 1'b1, va, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_bound[i] = '0; m_en[i] = 1'b0; end
        rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_bound = 0; cfg_en = 0;
        req_valid = 0; req_vaddr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7", rsp_valid, rsp_fault, rsp_paddr, 1'b0, 1'b0, 30'd0);
        rst_n = 1'b1;

        // R7: every entry disabled after reset
        for (int s = 0; s < 4; s++) rd({s[1:0], 30'h10}, "R7");

        // R1 R2: worked example and segment selection
        wr(2'd2, 30'h2000, 30'h1000, 1'b1);
        wr(2'd0, 30'h100000, 30'h800, 1'b1);
        rd({2'b10, 30'h200}, "R2");
        rd({2'b00, 30'h200}, "R1");
        // R3: limit edges
        rd({2'b10, 30'hFFF}, "R3");
        rd({2'b10, 30'h1000}, "R3");
        rd({2'b10, 30'h1001}, "R3");
        // R4: disabled entry with otherwise good contents
        wr(2'd1, 30'h4000, 30'h1000, 1'b0);
        rd({2'b01, 30'h10}, "R4");
        // R5: carry out of 30 bits
        wr(2'd3, 30'h3FFF_F000, 30'h3FFF_FFFF, 1'b1);
        rd({2'b11, 30'hFFF}, "R5");
        rd({2'b11, 30'h1000}, "R5");
        // R6: write and lookup together see old entry, then new
        cycle(1'b1, 2'd2, 30'h5000, 30'h1000, 1'b1, 1'b1, {2'b10, 30'h200}, "R6");
        rd({2'b10, 30'h200}, "R6");
        cycle(1'b1, 2'd0, 30'h0, 30'h0, 1'b0, 1'b1, {2'b00, 30'h20}, "R6");
        rd({2'b00, 30'h20}, "R6");
        // R8: idle cycle
        cycle(1'b0, 2'd0, 30'd0, 30'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, "R8");

        // Random mix with bias toward boundaries
        for (int n = 0; n < 400; n++) begin
            logic        we, rv, en;
            logic [1:0]  idx, s;
            logic [29:0] b, bd, off;
            int          pick;
            we  = ($urandom_range(0, 3) == 0);
            rv  = ($urandom_range(0, 4) != 0);
            idx = 2'($urandom_range(0, 3));
            en  = ($urandom_range(0, 5) != 0);
            b   = ($urandom_range(0, 3) == 0) ? 30'h3FFF_0000 + 30'($urandom_range(0, 32'hFFFF))
                                             : 30'($urandom);
            bd  = ($urandom_range(0, 1) == 0) ? 30'($urandom_range(1, 32'h2000)) : 30'($urandom);
            s   = 2'($urandom_range(0, 3));
            pick = $urandom_range(0, 4);
            case (pick)
                0: off = m_bound[s] - 30'd1;
                1: off = m_bound[s];
                2: off = m_bound[s] + 30'd1;
                3: off = 30'($urandom_range(0, 32'h1FFF));
                default: off = 30'($urandom);
            endcase
            cycle(we, idx, b, bd, en, rv, {s, off}, "");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule